// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two IEEE-754 operands, both single precision or both double precision, and turns the result into a 4-bit NZCV condition nibble. The nibble is placed in bits 31:28 of a 32-bit floating-point status word. All other bits of that word pass through from the caller's copy, except that an invalid-operation event is ORed into the sticky bit 0. A processor's floating-point pipeline uses the block to carry out its compare instructions. It supplies the current status word with every compare and writes back the returned word.

Two compare flavours are provided, selected per operation. The quiet compare raises invalid only for a signalling NaN. The signalling compare raises invalid for any NaN. Both flavours produce the same flag nibble. The block recognises NaNs, zeros of either sign and infinities, and does no arithmetic or rounding.

Control is a two-state machine. ST_IDLE is the reset state. When `start` is high, either state moves to ST_DONE, and the operation's results are registered on that same edge. When `start` is low, either state moves to ST_IDLE. `done` is high exactly while the machine is in ST_DONE. The flag, status and invalid outputs hold their values until the next accepted `start`.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Equal operands give flags 4'hC (N and Z). +0 and -0 compare equal.
- R2: When operand A is less than operand B, the flags are 4'h8 (N only).
- R3: When operand A is greater than operand B, the flags are 4'h2 (C only).
- R4: When either operand is a NaN, the result is unordered and the flags are 4'h3 (C and V). A NaN has an all-ones exponent and a nonzero mantissa.
- R5: Ordering follows the sign. Negative values order below positive values, and larger magnitudes of a negative sign order lower. Infinities and subnormals order like other values.
- R6: With `is_double` low, only bits 31:0 of each operand are used (sign 31, exponent 30:23, mantissa 22:0), and bits 63:32 have no effect. With `is_double` high, all 64 bits are used (sign 63, exponent 62:52, mantissa 51:0).
- R7: `status_out[31:28]` equals the flag nibble, and `status_out[27:1]` equals `status_in[27:1]` as sampled with `start`.
- R8: In quiet mode (`signalling` low), `invalid` is set only when an operand is a signalling NaN, which is a NaN whose top mantissa bit is 0.
- R9: In signalling mode (`signalling` high), `invalid` is set when either operand is any NaN.
- R10: `status_out[0]` is `status_in[0]` ORed with `invalid`.
- R11: `done` pulses high for one cycle, in the cycle after `start` is sampled. The results are valid in that cycle and hold until the next `start`.
- R12: After reset, `done`, `flags`, `status_out` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a compare on this edge |
| is_double | input | 1 | 1 = double precision, 0 = single precision in bits 31:0 |
| signalling | input | 1 | 1 = any NaN is invalid, 0 = only signalling NaN |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| status_in | input | 32 | Current status word to merge into |
| flags | output | 4 | NZCV result nibble |
| status_out | output | 32 | Updated status word |
| invalid | output | 1 | Invalid-operation indication |
| done | output | 1 | One-cycle result strobe |

## Verification
Every result is registered once, so flags, status word and invalid are due on the first rising edge after `start` is sampled, together with `done`. Each scenario task raises `start` at a falling edge and drops it at the next falling edge. It samples all outputs at that falling edge, halfway between the capturing edge and the following one. A timing scenario then waits one more falling edge to confirm that `done` has dropped and that the results have held.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int OP_W  = 64;
    localparam int MAG_W = OP_W - 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } fcmp_state_e;

    localparam logic [3:0] NZCV_EQ = 4'hC;
    localparam logic [3:0] NZCV_LT = 4'h8;
    localparam logic [3:0] NZCV_GT = 4'h2;
    localparam logic [3:0] NZCV_UN = 4'h3;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } fp_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23,
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52
) (
    input  logic            is_double,
    input  logic [OP_W-1:0] word,
    output fp_class_t       cls
);
    localparam int SP_W = 1 + SP_EXP + SP_MAN;
    localparam int DP_W = 1 + DP_EXP + DP_MAN;

    logic [SP_EXP-1:0] sp_exp;
    logic [SP_MAN-1:0] sp_man;
    logic [DP_EXP-1:0] dp_exp;
    logic [DP_MAN-1:0] dp_man;

    assign sp_exp = word[SP_MAN +: SP_EXP];
    assign sp_man = word[SP_MAN-1:0];
    assign dp_exp = word[DP_MAN +: DP_EXP];
    assign dp_man = word[DP_MAN-1:0];

    always_comb begin
        cls = '0;
        if (is_double) begin
            cls.sign = word[DP_W-1];
            cls.nan  = (&dp_exp) && (|dp_man);
            cls.snan = cls.nan && !dp_man[DP_MAN-1];
            cls.mag  = MAG_W'(word[DP_W-2:0]);
        end else begin
            cls.sign = word[SP_W-1];
            cls.nan  = (&sp_exp) && (|sp_man);
            cls.snan = cls.nan && !sp_man[SP_MAN-1];
            cls.mag  = MAG_W'(word[SP_W-2:0]);
        end
        cls.zero = (cls.mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_class_t  a,
    input  fp_class_t  b,
    input  logic       signalling,
    output logic [3:0] nzcv,
    output logic       invalid
);
    logic any_nan;
    logic any_snan;
    logic mag_below;

    assign any_nan   = a.nan  || b.nan;
    assign any_snan  = a.snan || b.snan;
    assign mag_below = a.mag < b.mag;

    always_comb begin
        if (any_nan)
            nzcv = NZCV_UN;
        else if (a.zero && b.zero)
            nzcv = NZCV_EQ;
        else if (a.sign != b.sign)
            nzcv = a.sign ? NZCV_LT : NZCV_GT;
        else if (a.mag == b.mag)
            nzcv = NZCV_EQ;
        else if (mag_below ^ a.sign)
            nzcv = NZCV_LT;
        else
            nzcv = NZCV_GT;
    end

    assign invalid = signalling ? any_nan : any_snan;

    always_comb begin
        if (!any_nan) begin
            assert_ordered_no_invalid_R8: assert (!invalid);
        end
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_double,
    input  logic        signalling,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic [31:0] status_in,
    output logic [3:0]  flags,
    output logic [31:0] status_out,
    output logic        invalid,
    output logic        done
);
    localparam int N_OPS = 2;

    fcmp_state_e     state_q, state_d;
    logic [OP_W-1:0] ops [N_OPS];
    fp_class_t       cls [N_OPS];
    logic [3:0]      nzcv_c;
    logic            inv_c;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fcmp_classify u_cls (
            .is_double (is_double),
            .word      (ops[i]),
            .cls       (cls[i])
        );
    end

    fcmp_order u_order (
        .a          (cls[0]),
        .b          (cls[1]),
        .signalling (signalling),
        .nzcv       (nzcv_c),
        .invalid    (inv_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags      <= '0;
            status_out <= '0;
            invalid    <= 1'b0;
        end else if (start) begin
            flags      <= nzcv_c;
            status_out <= {nzcv_c, status_in[27:1], status_in[0] | inv_c};
            invalid    <= inv_c;
        end
    end

    assign done = (state_q == ST_DONE);

    assert_done_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    assert_flags_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags == NZCV_EQ || flags == NZCV_LT || flags == NZCV_GT || flags == NZCV_UN));
    assert_nibble_in_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status_out[31:28] == flags);
    assert_low_bits_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status_out[27:1] == $past(status_in[27:1]));
    assert_sticky_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> status_out[0]);
    assert_invalid_unordered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> flags == NZCV_UN);
endmodule

// File: tb/fcmp_flag_unit_test.sv
module fcmp_flag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_double = 1'b0;
    logic        signalling = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [31:0] status_in = '0;
    logic [3:0]  flags;
    logic [31:0] status_out;
    logic        invalid;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fcmp_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_double(is_double),
        .signalling(signalling), .op_a(op_a), .op_b(op_b), .status_in(status_in),
        .flags(flags), .status_out(status_out), .invalid(invalid), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_cmp(input logic dbl, input logic sig, input logic [63:0] a,
                           input logic [63:0] b, input logic [31:0] st);
        @(negedge clk);
        is_double = dbl; signalling = sig; op_a = a; op_b = b; status_in = st;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = '1; op_b = '1; status_in = '0;
    endtask

    task automatic expect_res(input string req, input logic [3:0] ef, input logic ei,
                              input logic [31:0] st);
        check({req, " done"}, 32'(done), 32'd1);
        check({req, " flags"}, 32'(flags), 32'(ef));
        check({req, " invalid"}, 32'(invalid), 32'(ei));
        check({req, " status"}, status_out, {ef, st[27:1], st[0] | ei});
    endtask

    task automatic t_reset;
        check("R12 done", 32'(done), 32'd0);
        check("R12 flags", 32'(flags), 32'd0);
        check("R12 status", status_out, 32'd0);
        check("R12 invalid", 32'(invalid), 32'd0);
    endtask

    task automatic t_equal;
        run_cmp(1'b0, 1'b0, 64'h3F800000, 64'h3F800000, 32'h0);
        expect_res("R1 single eq", 4'hC, 1'b0, 32'h0);
        run_cmp(1'b1, 1'b0, 64'h8000000000000000, 64'h0, 32'h0);
        expect_res("R1 -0 == +0", 4'hC, 1'b0, 32'h0);
    endtask

    task automatic t_less;
        run_cmp(1'b0, 1'b0, 64'h3F800000, 64'h40000000, 32'h0);
        expect_res("R2 single 1<2", 4'h8, 1'b0, 32'h0);
        run_cmp(1'b1, 1'b0, 64'h3FF0000000000000, 64'h4000000000000000, 32'h0);
        expect_res("R2 double 1<2", 4'h8, 1'b0, 32'h0);
    endtask

    task automatic t_greater;
        run_cmp(1'b1, 1'b1, 64'h4000000000000000, 64'h3FF0000000000000, 32'h0);
        expect_res("R3 double 2>1", 4'h2, 1'b0, 32'h0);
        run_cmp(1'b0, 1'b0, 64'h00000001, 64'h00000000, 32'h0);
        expect_res("R3 subnormal>0", 4'h2, 1'b0, 32'h0);
    endtask

    task automatic t_unordered;
        run_cmp(1'b0, 1'b0, 64'h7FC00000, 64'h3F800000, 32'h0);
        expect_res("R4 qnan single", 4'h3, 1'b0, 32'h0);
        run_cmp(1'b1, 1'b0, 64'h3FF0000000000000, 64'h7FF8000000000000, 32'h0);
        expect_res("R4 qnan double", 4'h3, 1'b0, 32'h0);
        run_cmp(1'b0, 1'b0, 64'h7F800000, 64'h7F800000, 32'h0);
        expect_res("R4 inf is not nan", 4'hC, 1'b0, 32'h0);
    endtask

    task automatic t_signs;
        run_cmp(1'b0, 1'b0, 64'hBF800000, 64'h3F800000, 32'h0);
        expect_res("R5 -1<1", 4'h8, 1'b0, 32'h0);
        run_cmp(1'b1, 1'b0, 64'hC000000000000000, 64'hBFF0000000000000, 32'h0);
        expect_res("R5 -2<-1", 4'h8, 1'b0, 32'h0);
        run_cmp(1'b0, 1'b0, 64'hFF800000, 64'hBF800000, 32'h0);
        expect_res("R5 -inf<-1", 4'h8, 1'b0, 32'h0);
        run_cmp(1'b1, 1'b0, 64'h7FF0000000000000, 64'h4000000000000000, 32'h0);
        expect_res("R5 +inf>2", 4'h2, 1'b0, 32'h0);
    endtask

    task automatic t_single_upper;
        run_cmp(1'b0, 1'b1, 64'hFFFFFFFF_3F800000, 64'h00000000_40000000, 32'h0);
        expect_res("R6 upper ignored", 4'h8, 1'b0, 32'h0);
        run_cmp(1'b0, 1'b0, 64'h12345678_40000000, 64'h9ABCDEF0_40000000, 32'h0);
        expect_res("R6 upper ignored eq", 4'hC, 1'b0, 32'h0);
    endtask

    task automatic t_status_merge;
        run_cmp(1'b0, 1'b0, 64'h40000000, 64'h3F800000, 32'h5A5A5A5A);
        expect_res("R7 merge", 4'h2, 1'b0, 32'h5A5A5A5A);
        run_cmp(1'b0, 1'b0, 64'h3F800000, 64'h3F800000, 32'hA7FFFFFF);
        expect_res("R10 sticky kept", 4'hC, 1'b0, 32'hA7FFFFFF);
    endtask

    task automatic t_quiet_invalid;
        run_cmp(1'b0, 1'b0, 64'h7F800001, 64'h3F800000, 32'h0);
        expect_res("R8 quiet snan", 4'h3, 1'b1, 32'h0);
        run_cmp(1'b1, 1'b0, 64'h0, 64'h7FF0000000000001, 32'h00F00000);
        expect_res("R8 quiet snan double", 4'h3, 1'b1, 32'h00F00000);
    endtask

    task automatic t_signal_invalid;
        run_cmp(1'b0, 1'b1, 64'h7FC00000, 64'h3F800000, 32'h0);
        expect_res("R9 signalling qnan", 4'h3, 1'b1, 32'h0);
        run_cmp(1'b1, 1'b1, 64'h7FF8000000000000, 64'h0, 32'h12345678);
        expect_res("R9 R10 signalling qnan double", 4'h3, 1'b1, 32'h12345678);
        run_cmp(1'b0, 1'b1, 64'h3F800000, 64'h40000000, 32'h0);
        expect_res("R9 ordered no invalid", 4'h8, 1'b0, 32'h0);
    endtask

    task automatic t_timing;
        run_cmp(1'b0, 1'b0, 64'h40000000, 64'h3F800000, 32'h0000_0010);
        expect_res("R11 result", 4'h2, 1'b0, 32'h0000_0010);
        @(negedge clk);
        check("R11 done drops", 32'(done), 32'd0);
        check("R11 flags held", 32'(flags), 32'h2);
        check("R11 status held", status_out, 32'h2000_0010);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_equal();
        t_less();
        t_greater();
        t_unordered();
        t_signs();
        t_single_upper();
        t_status_merge();
        t_quiet_invalid();
        t_signal_invalid();
        t_timing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule